// File: doc/BRIEF.md
# Capture-Compare Timer with Pulse Generation

This block is a free-standing event timer. It has one up-counter, two holding registers that each work either as a compare value or as a capture latch, and a selectable count clock. Two external trigger inputs pass through a synchroniser and a width filter that runs on the count clock. They can latch the counter, clear and restart it, or start a single pulse. The block has one timer output pin and two event strobes, one for each holding register.

Configuration arrives as static input fields: operating mode, count-clock select, edge selects, capture/compare selects and output control. Holding registers in compare mode are loaded through a shared write-data port. The same timer serves as an interval timer, a period/duty waveform generator, a one-shot pulse generator and an input-capture unit. Which one it is depends on the configuration.

Top module: `cct_timer`

## Requirements
- R1: With `mode_i` = 00 the counter is held at zero. Any other mode value lets it count on count-clock ticks.
- R2: `prescale_i` 00, 01 and 10 give one tick every 1, 2^DIVA_LOG2 and 2^DIVB_LOG2 clock cycles. Code 11 holds the counter at zero.
- R3: In mode 11, with holding register 0 in compare mode, the counter returns to zero on the tick where it equals register 0. `irq0_o` pulses once per period of (register 0 + 1) ticks.
- R4: With `cc1_cap_i` = 1, a valid trigger-0 edge loads the counter value of that cycle into register 1 and pulses `irq1_o`. Edge selects are coded 00 falling, 01 rising, 10 both, 11 none.
- R5: A register in compare mode never takes a capture. A register in capture mode ignores writes and keeps its captured value through stop, until reset.
- R6: A trigger level counts only if it has been seen on two consecutive count-clock samples. Shorter pulses produce no event.
- R7: If a trigger input is already high when the block first leaves stop mode, it yields a rising edge. After any later stop and restart it does not.
- R8: With `cc0_cap_i` = 1 and `cc0_rev_i` = 1, register 0 captures on the opposite edge of trigger 0 and raises no `irq0_o`. A valid trigger-1 edge then captures nothing but still pulses `irq0_o`.
- R9: In mode 11, with both toggle enables set and register 1 < register 0, `tout_o` toggles on each register-1 match and each register-0 match. This gives a period of register 0 + 1 ticks and a high time of (register 0 − register 1) ticks.
- R10: In one-shot operation (mode 01, `osp_en_i` = 1), the counter rests at zero until a software trigger or a valid trigger-0 edge. The output rises on the register-1 match and falls on the register-0 match. The counter then clears and waits again.
- R11: Triggers that arrive while a one-shot pulse is running are ignored.
- R12: In mode 10 a valid trigger-0 edge clears the counter, and counting continues from zero.
- R13: `lvl_clr_i` forces the output low and `lvl_set_i` forces it high. With `out_en_i` = 0 the output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 stop, 01 free/one-shot, 10 clear on trigger-0 edge, 11 clear on register-0 match |
| prescale_i | input | 2 | Count-clock select |
| osp_en_i | input | 1 | One-shot operation in mode 01 |
| osp_trig_i | input | 1 | Software one-shot trigger strobe |
| cc0_cap_i | input | 1 | Register 0: 1 capture, 0 compare |
| cc1_cap_i | input | 1 | Register 1: 1 capture, 0 compare |
| cc0_rev_i | input | 1 | Register 0 captures on opposite trigger-0 edge |
| edge0_sel_i | input | 2 | Trigger-0 valid edge |
| edge1_sel_i | input | 2 | Trigger-1 valid edge |
| wdata_i | input | CNT_W | Compare value write data |
| cc0_wr_i | input | 1 | Write strobe for register 0 |
| cc1_wr_i | input | 1 | Write strobe for register 1 |
| out_en_i | input | 1 | Output enable |
| inv0_i | input | 1 | Toggle output on register-0 match |
| inv1_i | input | 1 | Toggle output on register-1 match |
| lvl_set_i | input | 1 | Force output high |
| lvl_clr_i | input | 1 | Force output low |
| trig0_i | input | 1 | Trigger input 0 |
| trig1_i | input | 1 | Trigger input 1 |
| cnt_o | output | CNT_W | Counter value |
| cc0_o | output | CNT_W | Holding register 0 |
| cc1_o | output | CNT_W | Holding register 1 |
| tout_o | output | 1 | Timer output |
| irq0_o | output | 1 | Register-0 match/capture strobe |
| irq1_o | output | 1 | Register-1 match/capture strobe |

## Verification
The bench builds the timer with CNT_W = 16, DIVA_LOG2 = 2 and DIVB_LOG2 = 4. The slow divider is therefore /16 rather than /256. This keeps an exact tick count of the slowest count clock within a 64-cycle window. The /4 setting gives the width filter a sample spacing long enough that a two-cycle trigger pulse falls between qualifying samples, while a sixteen-cycle pulse is accepted. Compare values are kept small, so interval, duty and one-shot timing are checked to the exact cycle.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    MODE_STOP     = 2'b00,
    MODE_FREE     = 2'b01,
    MODE_CLRSTART = 2'b10,
    MODE_INTERVAL = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PRE_DIV1 = 2'b00,
    PRE_DIVA = 2'b01,
    PRE_DIVB = 2'b10,
    PRE_TRIG = 2'b11
  } pre_e;

  localparam logic [1:0] EDGE_FALL = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_BOTH = 2'b10;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    case (sel)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // opposite phase of the selected edge
  function automatic logic edge_hit_rev(input logic [1:0] sel, input logic rise, input logic fall);
    case (sel)
      EDGE_FALL: edge_hit_rev = rise;
      EDGE_RISE: edge_hit_rev = fall;
      EDGE_BOTH: edge_hit_rev = rise | fall;
      default:   edge_hit_rev = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale
  import cct_pkg::*;
#(
  parameter int DIVA_LOG2 = 2,
  parameter int DIVB_LOG2 = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [DIVB_LOG2-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    case (pre_e'(sel_i))
      PRE_DIVA: tick_o = &pre_q[DIVA_LOG2-1:0];
      PRE_DIVB: tick_o = &pre_q;
      default:  tick_o = 1'b1; // div1; trigger code samples filter every cycle
    endcase
  end
endmodule

// File: rtl/cct_edge.sv
module cct_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  input  logic hold_i,
  input  logic gate_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_N-1:0] sync_q;
  logic s1_q, s2_q, filt_q, filt_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      filt_q   <= 1'b0;
      filt_d_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      if (hold_i) begin
        // before first enable: pretend the pin is low
        s1_q     <= 1'b0;
        s2_q     <= 1'b0;
        filt_q   <= 1'b0;
        filt_d_q <= 1'b0;
      end else begin
        if (tick_i) begin
          s1_q <= sync_q[SYNC_N-1];
          s2_q <= s1_q;
          if (s1_q == s2_q) filt_q <= s1_q;
        end
        filt_d_q <= filt_q;
      end
    end
  end

  assign rise_o = gate_i & filt_q & ~filt_d_q;
  assign fall_o = gate_i & ~filt_q & filt_d_q;
endmodule

// File: rtl/cct_outctl.sv
module cct_outctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_en_i,
  input  logic lvl_set_i,
  input  logic lvl_clr_i,
  input  logic osp_mode_i,
  input  logic inv0_i,
  input  logic inv1_i,
  input  logic match0_i,
  input  logic match1_i,
  output logic out_o
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               out_q <= 1'b0;
    else if (!out_en_i)                        out_q <= 1'b0;
    else if (lvl_clr_i)                        out_q <= 1'b0;
    else if (lvl_set_i)                        out_q <= 1'b1;
    else if (osp_mode_i) begin
      if (match0_i)                            out_q <= 1'b0;
      else if (match1_i)                       out_q <= 1'b1;
    end
    else if ((inv0_i & match0_i) ^ (inv1_i & match1_i)) out_q <= ~out_q;
  end

  assign out_o = out_q;
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DIVA_LOG2 = 2,
  parameter int DIVB_LOG2 = 8,
  parameter int SYNC_N    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       prescale_i,
  input  logic             osp_en_i,
  input  logic             osp_trig_i,
  input  logic             cc0_cap_i,
  input  logic             cc1_cap_i,
  input  logic             cc0_rev_i,
  input  logic [1:0]       edge0_sel_i,
  input  logic [1:0]       edge1_sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cc0_wr_i,
  input  logic             cc1_wr_i,
  input  logic             out_en_i,
  input  logic             inv0_i,
  input  logic             inv1_i,
  input  logic             lvl_set_i,
  input  logic             lvl_clr_i,
  input  logic             trig0_i,
  input  logic             trig1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cc0_o,
  output logic [CNT_W-1:0] cc1_o,
  output logic             tout_o,
  output logic             irq0_o,
  output logic             irq1_o
);
  localparam int NTRIG = 2;

  mode_e mode;
  assign mode = mode_e'(mode_i);

  logic             tick, run, first_q, hold;
  logic [NTRIG-1:0] trig, rise, fall;
  logic             ev0, ev0_rev, ev1;
  logic             osp_mode, osp_run_q, cnt_hold, active;
  logic             match0, match1, cap0, cap1, rev;
  logic [CNT_W-1:0] cnt_q, cc0_q, cc1_q;
  logic             irq0_q, irq1_q;

  cct_prescale #(.DIVA_LOG2(DIVA_LOG2), .DIVB_LOG2(DIVB_LOG2)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(prescale_i), .tick_o(tick)
  );

  assign run  = (mode != MODE_STOP);
  assign hold = first_q & ~run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  first_q <= 1'b1;
    else if (run) first_q <= 1'b0;
  end

  assign trig = {trig1_i, trig0_i};

  for (genvar g = 0; g < NTRIG; g++) begin : g_edge
    cct_edge #(.SYNC_N(SYNC_N)) u_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(trig[g]), .tick_i(tick),
      .hold_i(hold), .gate_i(run), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  assign ev0     = edge_hit(edge0_sel_i, rise[0], fall[0]);
  assign ev0_rev = edge_hit_rev(edge0_sel_i, rise[0], fall[0]);
  assign ev1     = edge_hit(edge1_sel_i, rise[1], fall[1]);

  assign osp_mode = (mode == MODE_FREE) & osp_en_i;
  assign cnt_hold = (pre_e'(prescale_i) == PRE_TRIG);
  assign active   = run & ~cnt_hold & (~osp_mode | osp_run_q);

  assign match0 = active & tick & ~cc0_cap_i & (cnt_q == cc0_q);
  assign match1 = active & tick & ~cc1_cap_i & (cnt_q == cc1_q);

  assign rev  = cc0_cap_i & cc0_rev_i;
  assign cap0 = cc0_cap_i & (rev ? ev0_rev : ev1);
  assign cap1 = cc1_cap_i & ev0;

  // counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cnt_q <= '0;
    else if (!run || cnt_hold)                      cnt_q <= '0;
    else if ((mode == MODE_CLRSTART) && ev0)        cnt_q <= '0;
    else if (osp_mode && !osp_run_q)                cnt_q <= '0;
    else if (tick) begin
      if (match0 && ((mode == MODE_INTERVAL) || osp_mode)) cnt_q <= '0;
      else                                          cnt_q <= cnt_q + 1'b1;
    end
  end

  // one-shot sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        osp_run_q <= 1'b0;
    else if (!osp_mode || cnt_hold)                     osp_run_q <= 1'b0;
    else if (!osp_run_q && (osp_trig_i || ev0))         osp_run_q <= 1'b1;
    else if (osp_run_q && match0)                       osp_run_q <= 1'b0;
  end

  // holding registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc0_q <= '0;
      cc1_q <= '0;
    end else begin
      if (cap0)                        cc0_q <= cnt_q;
      else if (cc0_wr_i && !cc0_cap_i) cc0_q <= wdata_i;
      if (cap1)                        cc1_q <= cnt_q;
      else if (cc1_wr_i && !cc1_cap_i) cc1_q <= wdata_i;
    end
  end

  // strobes; reverse-phase capture stays silent, trigger 1 then acts as plain event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= match0 | (cap0 & ~rev) | (rev & ev1);
      irq1_q <= match1 | cap1;
    end
  end

  cct_outctl u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .out_en_i(out_en_i), .lvl_set_i(lvl_set_i),
    .lvl_clr_i(lvl_clr_i), .osp_mode_i(osp_mode), .inv0_i(inv0_i), .inv1_i(inv1_i),
    .match0_i(match0), .match1_i(match1), .out_o(tout_o)
  );

  assign cnt_o  = cnt_q;
  assign cc0_o  = cc0_q;
  assign cc1_o  = cc1_q;
  assign irq0_o = irq0_q;
  assign irq1_o = irq1_q;
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [1:0]       prescale_i,
  input logic             osp_en_i,
  input logic             cc0_cap_i,
  input logic             cc1_cap_i,
  input logic             cc1_wr_i,
  input logic             out_en_i,
  input logic             lvl_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] cc1_o,
  input logic             tout_o,
  input logic             irq0_o
);
  assert_stop_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> cnt_o == '0);

  assert_trig_clk_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prescale_i == 2'b11 |=> cnt_o == '0);

  assert_interval_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i == 2'b11 && !cc0_cap_i && prescale_i != 2'b11) && irq0_o) |-> cnt_o == '0);

  assert_compare_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cc1_wr_i && !cc1_cap_i) |=> $stable(cc1_o));

  assert_osp_end_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i == 2'b01 && osp_en_i && out_en_i && !lvl_clr_i && prescale_i != 2'b11)
     && out_en_i && $fell(tout_o)) |-> cnt_o == '0);
endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .prescale_i(prescale_i),
  .osp_en_i(osp_en_i), .cc0_cap_i(cc0_cap_i), .cc1_cap_i(cc1_cap_i), .cc1_wr_i(cc1_wr_i),
  .out_en_i(out_en_i), .lvl_clr_i(lvl_clr_i), .cnt_o(cnt_o), .cc1_o(cc1_o),
  .tout_o(tout_o), .irq0_o(irq0_o)
);

// File: tb/cct_timer_bench.sv
`timescale 1ns/1ps
module cct_timer_bench;
  localparam int CNT_W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00, prescale_i = 2'b00, edge0_sel_i = 2'b01, edge1_sel_i = 2'b01;
  logic osp_en_i = 0, osp_trig_i = 0, cc0_cap_i = 0, cc1_cap_i = 0, cc0_rev_i = 0;
  logic [CNT_W-1:0] wdata_i = '0;
  logic cc0_wr_i = 0, cc1_wr_i = 0, out_en_i = 0, inv0_i = 0, inv1_i = 0;
  logic lvl_set_i = 0, lvl_clr_i = 0, trig0_i = 0, trig1_i = 0;
  logic [CNT_W-1:0] cnt_o, cc0_o, cc1_o;
  logic tout_o, irq0_o, irq1_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cct_timer #(.CNT_W(CNT_W), .DIVA_LOG2(2), .DIVB_LOG2(4)) u_cct_timer (
    .clk_i, .rst_ni, .mode_i, .prescale_i, .osp_en_i, .osp_trig_i, .cc0_cap_i, .cc1_cap_i,
    .cc0_rev_i, .edge0_sel_i, .edge1_sel_i, .wdata_i, .cc0_wr_i, .cc1_wr_i, .out_en_i,
    .inv0_i, .inv1_i, .lvl_set_i, .lvl_clr_i, .trig0_i, .trig1_i, .cnt_o, .cc0_o, .cc1_o,
    .tout_o, .irq0_o, .irq1_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_cc(input int which, input int val);
    wdata_i = CNT_W'(val);
    if (which == 0) cc0_wr_i = 1; else cc1_wr_i = 1;
    cyc(1);
    cc0_wr_i = 0; cc1_wr_i = 0;
  endtask

  task automatic pulse_lvl(input bit set);
    if (set) lvl_set_i = 1; else lvl_clr_i = 1;
    cyc(1);
    lvl_set_i = 0; lvl_clr_i = 0;
  endtask

  // watch a strobe; pc = counter value in the cycle before the first strobe
  task automatic wait_irq(input int which, input int maxc, output bit got, output int pc);
    int prev;
    got = 0; pc = 0; prev = int'(cnt_o);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk_i);
      if (((which == 0) ? irq0_o : irq1_o) && !got) begin got = 1; pc = prev; end
      prev = int'(cnt_o);
    end
  endtask

  task automatic t_reset;
    chk(cnt_o == 0, "R1 reset cnt", int'(cnt_o), 0);
    chk(tout_o == 0 && irq0_o == 0 && irq1_o == 0, "R13 reset outputs", int'(tout_o), 0);
    chk(cc0_o == 0 && cc1_o == 0, "R5 reset regs", int'(cc0_o), 0);
  endtask

  task automatic t_first_enable; // R7
    bit got; int pc;
    trig0_i = 1; edge0_sel_i = 2'b01; cc1_cap_i = 1;
    cyc(6);
    mode_i = 2'b01;
    wait_irq(1, 15, got, pc);
    chk(got, "R7 high at first enable seen as rise", int'(got), 1);
    chk(int'(cc1_o) == pc, "R4 capture value", int'(cc1_o), pc);
    mode_i = 2'b00; cyc(5);
    mode_i = 2'b01;
    wait_irq(1, 20, got, pc);
    chk(!got, "R7 no rise after restart", int'(got), 0);
  endtask

  task automatic t_capture; // R4
    bit got; int pc;
    edge0_sel_i = 2'b00; // falling
    trig0_i = 0;
    wait_irq(1, 15, got, pc);
    chk(got, "R4 falling edge captures", int'(got), 1);
    chk(int'(cc1_o) == pc, "R4 falling capture value", int'(cc1_o), pc);
    trig0_i = 1;
    wait_irq(1, 15, got, pc);
    chk(!got, "R4 rising ignored with falling select", int'(got), 0);
    trig0_i = 0;
    wait_irq(1, 15, got, pc);
    chk(got && int'(cc1_o) == pc, "R4 second capture value", int'(cc1_o), pc);
  endtask

  task automatic t_filter; // R6
    bit got; int pc; int old;
    edge0_sel_i = 2'b01; prescale_i = 2'b01;
    cyc(10);
    old = int'(cc1_o);
    trig0_i = 1; cyc(2); trig0_i = 0;
    wait_irq(1, 30, got, pc);
    chk(!got, "R6 short pulse rejected", int'(got), 0);
    chk(int'(cc1_o) == old, "R6 register unchanged", int'(cc1_o), old);
    trig0_i = 1;
    wait_irq(1, 30, got, pc);
    chk(got, "R6 long pulse accepted", int'(got), 1);
    trig0_i = 0; prescale_i = 2'b00;
    cyc(10);
  endtask

  task automatic t_hold; // R5
    bit got; int pc; int x;
    x = int'(cc1_o);
    wr_cc(1, 16'h1234); cyc(2);
    chk(int'(cc1_o) == x, "R5 write ignored in capture mode", int'(cc1_o), x);
    mode_i = 2'b00; cyc(10);
    chk(int'(cc1_o) == x, "R5 capture held through stop", int'(cc1_o), x);
    cc1_cap_i = 0;
    wr_cc(1, 16'h7000); cyc(1);
    chk(cc1_o == 16'h7000, "R5 compare write", int'(cc1_o), 16'h7000);
    mode_i = 2'b01; cyc(3);
    trig0_i = 1;
    wait_irq(1, 15, got, pc);
    chk(!got && cc1_o == 16'h7000, "R5 compare ignores capture", int'(cc1_o), 16'h7000);
    trig0_i = 0; cyc(10);
  endtask

  task automatic t_prescale; // R2
    int c0;
    wr_cc(0, 16'hFFFF);
    mode_i = 2'b01;
    prescale_i = 2'b00; cyc(1); c0 = int'(cnt_o); cyc(16);
    chk(16'(int'(cnt_o) - c0) == 16, "R2 div1", int'(cnt_o) - c0, 16);
    prescale_i = 2'b01; cyc(1); c0 = int'(cnt_o); cyc(32);
    chk(16'(int'(cnt_o) - c0) == 8, "R2 divA", int'(cnt_o) - c0, 8);
    prescale_i = 2'b10; cyc(1); c0 = int'(cnt_o); cyc(64);
    chk(16'(int'(cnt_o) - c0) == 4, "R2 divB", int'(cnt_o) - c0, 4);
    prescale_i = 2'b11; cyc(3);
    chk(cnt_o == 0, "R2 trigger clock holds zero", int'(cnt_o), 0);
    cyc(10);
    chk(cnt_o == 0, "R2 still zero", int'(cnt_o), 0);
    prescale_i = 2'b00; cyc(1);
    mode_i = 2'b00; cyc(2);
    chk(cnt_o == 0, "R1 stop clears", int'(cnt_o), 0);
    cyc(5);
    chk(cnt_o == 0, "R1 stop halts", int'(cnt_o), 0);
  endtask

  task automatic t_interval; // R3
    int t1, t2, n;
    wr_cc(0, 7);
    mode_i = 2'b11;
    t1 = -1; t2 = -1; n = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (irq0_o) begin
        if (t1 < 0) t1 = i; else if (t2 < 0) t2 = i;
        if (cnt_o == 0) n++;
      end
    end
    chk(t2 - t1 == 8, "R3 interval period", t2 - t1, 8);
    chk(t1 >= 0 && n >= 2, "R3 counter zero at strobe", n, 2);
    mode_i = 2'b00; cyc(2);
  endtask

  task automatic t_ppg; // R9
    int hi, r1, r2; logic p;
    wr_cc(0, 9); wr_cc(1, 3);
    out_en_i = 1; inv0_i = 1; inv1_i = 1;
    pulse_lvl(0);
    mode_i = 2'b11; cyc(25);
    hi = 0; for (int i = 0; i < 20; i++) begin cyc(1); if (tout_o) hi++; end
    chk(hi == 12, "R9 duty high cycles", hi, 12);
    r1 = -1; r2 = -1; p = tout_o;
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      if (tout_o && !p) begin if (r1 < 0) r1 = i; else if (r2 < 0) r2 = i; end
      p = tout_o;
    end
    chk(r2 - r1 == 10, "R9 period", r2 - r1, 10);
    mode_i = 2'b00; inv0_i = 0; inv1_i = 0;
    pulse_lvl(0); cyc(2);
  endtask

  task automatic t_osp; // R10 R11
    int hi;
    wr_cc(0, 12); wr_cc(1, 4);
    osp_en_i = 1; out_en_i = 1; edge0_sel_i = 2'b01; trig0_i = 0;
    mode_i = 2'b01; cyc(6);
    chk(cnt_o == 0 && tout_o == 0, "R10 idle before trigger", int'(cnt_o), 0);
    osp_trig_i = 1; cyc(1); osp_trig_i = 0;
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (tout_o) hi++;
      osp_trig_i = (i == 8); // retrigger during the pulse
    end
    osp_trig_i = 0;
    chk(hi == 8, "R11 retrigger ignored, single pulse width", hi, 8);
    chk(cnt_o == 0 && tout_o == 0, "R10 stops cleared after pulse", int'(cnt_o), 0);
    trig0_i = 1;
    hi = 0;
    for (int i = 0; i < 40; i++) begin cyc(1); if (tout_o) hi++; end
    chk(hi == 8, "R10 edge-triggered pulse width", hi, 8);
    chk(cnt_o == 0, "R10 counter parked", int'(cnt_o), 0);
    trig0_i = 0; mode_i = 2'b00; osp_en_i = 0; out_en_i = 0; cyc(10);
  endtask

  task automatic t_rev; // R8
    bit got; int pc; int lo, hi, keep;
    wr_cc(1, 16'hFFF0);
    cc0_cap_i = 1; cc0_rev_i = 1; edge0_sel_i = 2'b01; edge1_sel_i = 2'b01;
    mode_i = 2'b01;
    trig0_i = 1; cyc(30);
    lo = int'(cnt_o);
    trig0_i = 0;
    wait_irq(0, 15, got, pc);
    hi = int'(cnt_o);
    chk(!got, "R8 reverse capture raises no strobe", int'(got), 0);
    chk(int'(cc0_o) > lo && int'(cc0_o) <= hi, "R8 reverse capture value", int'(cc0_o), lo + 1);
    keep = int'(cc0_o);
    trig1_i = 1;
    wait_irq(0, 15, got, pc);
    chk(got, "R8 trigger 1 still strobes", int'(got), 1);
    chk(int'(cc0_o) == keep, "R8 trigger 1 does not capture", int'(cc0_o), keep);
    trig1_i = 0; mode_i = 2'b00; cc0_cap_i = 0; cc0_rev_i = 0; cyc(5);
  endtask

  task automatic t_clrstart; // R12
    int prev; bit seen; int v;
    wr_cc(0, 16'hFFFF);
    edge0_sel_i = 2'b01; trig0_i = 0;
    mode_i = 2'b10; cyc(40);
    trig0_i = 1;
    seen = 0; v = -1; prev = int'(cnt_o);
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      if (!seen && int'(cnt_o) < prev) begin seen = 1; v = int'(cnt_o); end
      prev = int'(cnt_o);
    end
    chk(seen && v == 0, "R12 edge clears and restarts", v, 0);
    chk(cnt_o > 0, "R12 counting continues", int'(cnt_o), 1);
    trig0_i = 0; mode_i = 2'b00; cyc(3);
  endtask

  task automatic t_level; // R13
    out_en_i = 1;
    pulse_lvl(1);
    chk(tout_o == 1, "R13 set level", int'(tout_o), 1);
    pulse_lvl(0);
    chk(tout_o == 0, "R13 clear level", int'(tout_o), 0);
    pulse_lvl(1);
    out_en_i = 0; cyc(1);
    chk(tout_o == 0, "R13 disable forces low", int'(tout_o), 0);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(2);
    t_reset;
    t_first_enable;
    t_capture;
    t_filter;
    t_hold;
    t_prescale;
    t_interval;
    t_ppg;
    t_osp;
    t_rev;
    t_clrstart;
    t_level;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run;
    end
  end
endmodule